// File: doc/BRIEF.md
# Intra 4x4 Orthogonal and DC Predictor

This block builds a 4x4 block of predicted pixels from the reconstructed samples next to it. The caller presents four samples from the column to the left, four from the row above, and one flag for each of those two edges that says whether it may be used. A mode code selects one of three modes. Vertical mode copies the above row into every row. Horizontal mode copies each left sample across its row. DC mode fills the block with one rounded mean of whichever edges are available.

The caller asserts an input strobe for one cycle. The block captures the prediction and presents all sixteen pixels, together with an output strobe, on the next clock. The result stays on the outputs until the next strobe. A mode code outside the three supported ones raises a flag and gives an all-zero block. Pixel width and block edge length are parameters. The accumulator is sized from them so that the widest sum cannot overflow.

Top module: `intra4_orth_pred`

## Requirements
- R1: With mode code 0 (vertical), every output row equals U0..U3: pixel (row r, column c) equals Uc. Sample i of `left_pix`/`up_pix` sits at bits [8i+7:8i], and pixel (r,c) of `pred_pix` sits at bits [8(4r+c)+7:8(4r+c)].
- R2: With mode code 1 (horizontal), every pixel of row r equals Lr.
- R3: With mode code 2 (DC) and both edges available, every pixel equals (L0+L1+L2+L3+U0+U1+U2+U3+4)>>3.
- R4: In DC mode with only the left edge available, every pixel equals (L0+L1+L2+L3+2)>>2.
- R5: In DC mode with only the upper edge available, every pixel equals (U0+U1+U2+U3+2)>>2.
- R6: In DC mode with neither edge available, every pixel equals 128.
- R7: In DC mode all sixteen output pixels carry the same value.
- R8: The largest possible sums, with every input sample at 255, produce 255 and never wrap.
- R9: `out_valid` is high in exactly the cycle after each cycle in which `in_valid` is high, and low otherwise. Back-to-back strobes give back-to-back results.
- R10: While `in_valid` is low, changes on the data, mode and availability inputs do not affect `pred_pix` or `mode_unsupported`. Both hold their last result.
- R11: Mode codes 3 to 15 set `mode_unsupported` and drive `pred_pix` to all zeros. Codes 0 to 2 clear the flag.
- R12: While `rst_n` is low, and after it, until the first strobe, `out_valid`, `mode_unsupported` and `pred_pix` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Captures a new prediction request |
| mode | input | 4 | 0 vertical, 1 horizontal, 2 DC, others unsupported |
| left_avail | input | 1 | Left edge may be used for DC |
| up_avail | input | 1 | Upper edge may be used for DC |
| left_pix | input | 32 | L0..L3, L0 in the low byte |
| up_pix | input | 32 | U0..U3, U0 in the low byte |
| out_valid | output | 1 | One-cycle strobe marking a new result |
| pred_pix | output | 128 | Sixteen predicted pixels, row-major, pixel (0,0) in the low byte |
| mode_unsupported | output | 1 | Result came from an unsupported mode code |

## Verification
Several properties are checked on every cycle: the one-cycle strobe latency, the all-zero block whenever the unsupported flag is set, the flag's agreement with the captured mode code, the flat DC block, the vertical copy of the above row, the mid-grey DC value when no edge is available, and a guard that the rounded DC sum fits in a pixel. The exact DC arithmetic for each availability case, the horizontal layout, the rounding at half-way sums, the saturating case with every sample at 255, and the holding of results between strobes can only be shown by the bench. It does this by comparing against values it computes itself.

// File: rtl/intra4_pkg.sv
package intra4_pkg;

   localparam int MODE_W = 4;

   localparam logic [MODE_W-1:0] PM_VERT = 4'd0;
   localparam logic [MODE_W-1:0] PM_HORZ = 4'd1;
   localparam logic [MODE_W-1:0] PM_DC   = 4'd2;

   // highest code the block implements
   localparam logic [MODE_W-1:0] PM_LAST = PM_DC;

   typedef enum logic [1:0] {
      EDGE_NONE = 2'b00,
      EDGE_UP   = 2'b01,
      EDGE_LEFT = 2'b10,
      EDGE_BOTH = 2'b11
   } edge_set_e;

endpackage

// File: rtl/intra4_edge_sum.sv
module intra4_edge_sum #(
   parameter int PIX_W = 8,
   parameter int BLK   = 4,
   parameter int ACC_W = 11
) (
   input  logic [BLK*PIX_W-1:0] samples,
   output logic [ACC_W-1:0]     total
);

   initial begin
      assert (ACC_W >= PIX_W + $clog2(BLK))
         else $error("intra4_edge_sum: accumulator too narrow");
   end

   always_comb begin
      total = '0;
      for (int i = 0; i < BLK; i++) begin
         total = total + ACC_W'(samples[i*PIX_W +: PIX_W]);
      end
   end

endmodule

// File: rtl/intra4_dc_sel.sv
module intra4_dc_sel
   import intra4_pkg::*;
#(
   parameter int PIX_W = 8,
   parameter int BLK   = 4,
   parameter int ACC_W = 11
) (
   input  logic [ACC_W-1:0] sum_left,
   input  logic [ACC_W-1:0] sum_up,
   input  logic             left_ok,
   input  logic             up_ok,
   output logic [PIX_W-1:0] dc_val
);

   localparam int SH_ONE  = $clog2(BLK);
   localparam int SH_BOTH = SH_ONE + 1;
   localparam logic [ACC_W-1:0] RND_ONE  = ACC_W'(BLK / 2);
   localparam logic [ACC_W-1:0] RND_BOTH = ACC_W'(BLK);
   localparam logic [PIX_W-1:0] MID_GREY = PIX_W'(1) << (PIX_W - 1);

   logic [ACC_W-1:0] avg_both;
   logic [ACC_W-1:0] avg_left;
   logic [ACC_W-1:0] avg_up;
   edge_set_e        edges;

   assign avg_both = (sum_left + sum_up + RND_BOTH) >> SH_BOTH;
   assign avg_left = (sum_left + RND_ONE) >> SH_ONE;
   assign avg_up   = (sum_up   + RND_ONE) >> SH_ONE;
   assign edges    = edge_set_e'({left_ok, up_ok});

   always_comb begin
      unique case (edges)
         EDGE_BOTH: dc_val = avg_both[PIX_W-1:0];
         EDGE_LEFT: dc_val = avg_left[PIX_W-1:0];
         EDGE_UP:   dc_val = avg_up[PIX_W-1:0];
         default:   dc_val = MID_GREY;
      endcase
   end

   // rounded means must fit in one pixel before truncation
   always_comb begin
      AST_NO_OVERFLOW: assert (avg_both[ACC_W-1:PIX_W] == '0 &&
                               avg_left[ACC_W-1:PIX_W] == '0 &&
                               avg_up[ACC_W-1:PIX_W]   == '0); // R8
   end

endmodule

// File: rtl/intra4_fill.sv
module intra4_fill
   import intra4_pkg::*;
#(
   parameter int PIX_W = 8,
   parameter int BLK   = 4
) (
   input  logic [MODE_W-1:0]        mode,
   input  logic [BLK*PIX_W-1:0]     left_pix,
   input  logic [BLK*PIX_W-1:0]     up_pix,
   input  logic [PIX_W-1:0]         dc_val,
   output logic [BLK*BLK*PIX_W-1:0] block,
   output logic                     unsupported
);

   assign unsupported = (mode > PM_LAST);

   for (genvar r = 0; r < BLK; r++) begin : g_row
      for (genvar c = 0; c < BLK; c++) begin : g_col
         localparam int IDX = r * BLK + c;
         always_comb begin
            unique case (mode)
               PM_VERT: block[IDX*PIX_W +: PIX_W] = up_pix[c*PIX_W +: PIX_W];
               PM_HORZ: block[IDX*PIX_W +: PIX_W] = left_pix[r*PIX_W +: PIX_W];
               PM_DC:   block[IDX*PIX_W +: PIX_W] = dc_val;
               default: block[IDX*PIX_W +: PIX_W] = '0;
            endcase
         end
      end
   end

endmodule

// File: rtl/intra4_orth_pred.sv
module intra4_orth_pred
   import intra4_pkg::*;
#(
   parameter int PIX_W = 8,
   parameter int BLK   = 4
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     in_valid,
   input  logic [MODE_W-1:0]        mode,
   input  logic                     left_avail,
   input  logic                     up_avail,
   input  logic [BLK*PIX_W-1:0]     left_pix,
   input  logic [BLK*PIX_W-1:0]     up_pix,
   output logic                     out_valid,
   output logic [BLK*BLK*PIX_W-1:0] pred_pix,
   output logic                     mode_unsupported
);

   localparam int NPIX  = BLK * BLK;
   localparam int ACC_W = PIX_W + $clog2(2 * BLK);
   localparam logic [PIX_W-1:0] MID_GREY = PIX_W'(1) << (PIX_W - 1);

   initial begin
      assert (PIX_W >= 2) else $error("intra4_orth_pred: PIX_W too small");
      assert (BLK >= 2 && (BLK & (BLK - 1)) == 0)
         else $error("intra4_orth_pred: BLK must be a power of two");
   end

   logic [ACC_W-1:0]        sum_l;
   logic [ACC_W-1:0]        sum_u;
   logic [PIX_W-1:0]        dc_val;
   logic [NPIX*PIX_W-1:0]   block_d;
   logic                    unsup_d;

   intra4_edge_sum #(.PIX_W(PIX_W), .BLK(BLK), .ACC_W(ACC_W)) u_sum_left (
      .samples (left_pix),
      .total   (sum_l)
   );

   intra4_edge_sum #(.PIX_W(PIX_W), .BLK(BLK), .ACC_W(ACC_W)) u_sum_up (
      .samples (up_pix),
      .total   (sum_u)
   );

   intra4_dc_sel #(.PIX_W(PIX_W), .BLK(BLK), .ACC_W(ACC_W)) u_dc (
      .sum_left (sum_l),
      .sum_up   (sum_u),
      .left_ok  (left_avail),
      .up_ok    (up_avail),
      .dc_val   (dc_val)
   );

   intra4_fill #(.PIX_W(PIX_W), .BLK(BLK)) u_fill (
      .mode        (mode),
      .left_pix    (left_pix),
      .up_pix      (up_pix),
      .dc_val      (dc_val),
      .block       (block_d),
      .unsupported (unsup_d)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid        <= 1'b0;
         pred_pix         <= '0;
         mode_unsupported <= 1'b0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) begin
            pred_pix         <= block_d;
            mode_unsupported <= unsup_d;
         end
      end
   end

   AST_OUT_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid); // R9

   AST_OUT_ORIGIN: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> $past(in_valid)); // R9

   AST_UNSUP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      mode_unsupported |-> (pred_pix == '0)); // R11

   AST_UNSUP_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (mode_unsupported == ($past(mode) > PM_LAST))); // R11

   AST_DC_FLAT: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && $past(mode) == PM_DC) |->
         (pred_pix == {NPIX{pred_pix[PIX_W-1:0]}})); // R7

   AST_VERT_COPY: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && $past(mode) == PM_VERT) |->
         (pred_pix == {BLK{$past(up_pix)}})); // R1

   AST_MID_GREY: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && $past(mode) == PM_DC && !$past(left_avail) && !$past(up_avail)) |->
         (pred_pix[PIX_W-1:0] == MID_GREY)); // R6

endmodule

// File: tb/intra4_orth_pred_test.sv
`timescale 1ns/1ps
module intra4_orth_pred_test;

   typedef struct packed {
      logic [3:0]  m;
      logic        la;
      logic        ua;
      logic [31:0] l;
      logic [31:0] u;
      logic [7:0]  req;
   } vec_t;

   localparam int NV = 13;
   // req field: number of the requirement the entry targets
   localparam vec_t VECS [NV] = '{
      '{4'd0,  1'b1, 1'b1, 32'h04030201, 32'hDDCCBBAA, 8'd1},  // R1
      '{4'd0,  1'b0, 1'b0, 32'h11223344, 32'h01800FF0, 8'd1},  // R1 ignores flags
      '{4'd1,  1'b1, 1'b1, 32'h40302010, 32'h99999999, 8'd2},  // R2
      '{4'd2,  1'b1, 1'b1, 32'h281E140A, 32'h50463C32, 8'd3},  // R3 -> 45
      '{4'd2,  1'b1, 1'b1, 32'h00000000, 32'h00000004, 8'd3},  // R3 half rounds up
      '{4'd2,  1'b1, 1'b1, 32'h00000000, 32'h00000003, 8'd3},  // R3 below half
      '{4'd2,  1'b1, 1'b0, 32'h05030201, 32'hFFFFFFFF, 8'd4},  // R4 -> 3
      '{4'd2,  1'b1, 1'b0, 32'h00000002, 32'h00000000, 8'd4},  // R4 -> 1
      '{4'd2,  1'b0, 1'b1, 32'h12345678, 32'hFEFFFFFF, 8'd5},  // R5 -> 255
      '{4'd2,  1'b0, 1'b0, 32'hFFFFFFFF, 32'hFFFFFFFF, 8'd6},  // R6 -> 128
      '{4'd2,  1'b1, 1'b1, 32'hFFFFFFFF, 32'hFFFFFFFF, 8'd8},  // R8 -> 255
      '{4'd3,  1'b1, 1'b1, 32'hA5A5A5A5, 32'h5A5A5A5A, 8'd11}, // R11
      '{4'd15, 1'b1, 1'b1, 32'h01010101, 32'h02020202, 8'd11}  // R11
   };

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         in_valid = 1'b0;
   logic [3:0]   mode = '0;
   logic         left_avail = 1'b0;
   logic         up_avail = 1'b0;
   logic [31:0]  left_pix = '0;
   logic [31:0]  up_pix = '0;
   logic         out_valid;
   logic [127:0] pred_pix;
   logic         mode_unsupported;

   int checks = 0;
   int errors = 0;

   always #10 clk = ~clk;

   intra4_orth_pred uut (
      .clk              (clk),
      .rst_n            (rst_n),
      .in_valid         (in_valid),
      .mode             (mode),
      .left_avail       (left_avail),
      .up_avail         (up_avail),
      .left_pix         (left_pix),
      .up_pix           (up_pix),
      .out_valid        (out_valid),
      .pred_pix         (pred_pix),
      .mode_unsupported (mode_unsupported)
   );

   function automatic logic [127:0] ref_block(logic [3:0] m, logic la, logic ua,
                                              logic [31:0] l, logic [31:0] u);
      logic [127:0] b;
      int sl, su, dc;
      b  = '0;
      sl = 0;
      su = 0;
      for (int i = 0; i < 4; i++) begin
         sl += int'(l[i*8 +: 8]);
         su += int'(u[i*8 +: 8]);
      end
      if (la && ua)      dc = (sl + su + 4) / 8;
      else if (la)       dc = (sl + 2) / 4;
      else if (ua)       dc = (su + 2) / 4;
      else               dc = 128;
      for (int r = 0; r < 4; r++) begin
         for (int c = 0; c < 4; c++) begin
            case (m)
               4'd0:    b[(r*4+c)*8 +: 8] = u[c*8 +: 8];
               4'd1:    b[(r*4+c)*8 +: 8] = l[r*8 +: 8];
               4'd2:    b[(r*4+c)*8 +: 8] = 8'(dc);
               default: b[(r*4+c)*8 +: 8] = 8'h00;
            endcase
         end
      end
      return b;
   endfunction

   task automatic check(input bit ok, input string req,
                        input logic [127:0] act, input logic [127:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic drive(input vec_t v);
      mode       = v.m;
      left_avail = v.la;
      up_avail   = v.ua;
      left_pix   = v.l;
      up_pix     = v.u;
   endtask

   task automatic finish_run();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog R9 actual=timeout expected=completion");
      finish_run();
   end

   initial begin
      logic [127:0] exp_b;
      logic [127:0] held;

      // R12: reset state
      repeat (3) @(negedge clk);
      check(out_valid == 1'b0 && pred_pix == '0 && mode_unsupported == 1'b0,
            "R12 during reset", {out_valid, mode_unsupported, pred_pix[125:0]}, '0);
      rst_n = 1'b1;
      @(negedge clk);
      check(out_valid == 1'b0 && pred_pix == '0, "R12 after reset",
            {out_valid, pred_pix[126:0]}, '0);

      // table walk: R1 R2 R3 R4 R5 R6 R7 R8 R11
      for (int k = 0; k < NV; k++) begin
         drive(VECS[k]);
         in_valid = 1'b1;
         @(negedge clk);
         in_valid = 1'b0;
         exp_b = ref_block(VECS[k].m, VECS[k].la, VECS[k].ua, VECS[k].l, VECS[k].u);
         check(out_valid == 1'b1, $sformatf("R9 strobe vec %0d", k),
               128'(out_valid), 128'd1);
         check(pred_pix == exp_b, $sformatf("R%0d vec %0d", VECS[k].req, k),
               pred_pix, exp_b);
         check(mode_unsupported == (VECS[k].m > 4'd2),
               $sformatf("R11 flag vec %0d", k),
               128'(mode_unsupported), 128'(VECS[k].m > 4'd2));
         if (VECS[k].m == 4'd2)
            check(pred_pix == {16{pred_pix[7:0]}}, $sformatf("R7 flat vec %0d", k),
                  pred_pix, {16{pred_pix[7:0]}});
         @(negedge clk);
         check(out_valid == 1'b0, $sformatf("R9 single pulse vec %0d", k),
               128'(out_valid), 128'd0);
      end

      // R3 explicit value check
      drive(VECS[3]);
      in_valid = 1'b1;
      @(negedge clk);
      in_valid = 1'b0;
      check(pred_pix[7:0] == 8'd45, "R3 value 45", 128'(pred_pix[7:0]), 128'd45);

      // R10: inputs change without strobe, result holds
      held = pred_pix;
      for (int k = 0; k < 4; k++) begin
         drive(VECS[11 - k]);
         @(negedge clk);
         check(out_valid == 1'b0, "R10 no strobe", 128'(out_valid), 128'd0);
         check(pred_pix == held && mode_unsupported == 1'b0, "R10 hold",
               pred_pix, held);
      end

      // R9: back-to-back strobes
      drive(VECS[0]);
      in_valid = 1'b1;
      @(negedge clk);
      exp_b = ref_block(VECS[0].m, VECS[0].la, VECS[0].ua, VECS[0].l, VECS[0].u);
      check(out_valid && pred_pix == exp_b, "R9 back-to-back first", pred_pix, exp_b);
      drive(VECS[2]);
      @(negedge clk);
      in_valid = 1'b0;
      exp_b = ref_block(VECS[2].m, VECS[2].la, VECS[2].ua, VECS[2].l, VECS[2].u);
      check(out_valid && pred_pix == exp_b, "R9 back-to-back second", pred_pix, exp_b);
      @(negedge clk);
      check(out_valid == 1'b0, "R9 back-to-back end", 128'(out_valid), 128'd0);

      // R11 then supported mode clears the flag
      drive(VECS[12]);
      in_valid = 1'b1;
      @(negedge clk);
      drive(VECS[9]);
      @(negedge clk);
      in_valid = 1'b0;
      check(mode_unsupported == 1'b0 && pred_pix == {16{8'd128}},
            "R11 flag clears / R6", pred_pix, {16{8'd128}});

      // R12: reset mid-run clears outputs
      rst_n = 1'b0;
      @(negedge clk);
      check(out_valid == 1'b0 && pred_pix == '0 && mode_unsupported == 1'b0,
            "R12 reset mid-run", pred_pix, '0);
      rst_n = 1'b1;
      @(negedge clk);

      finish_run();
   end

endmodule